// File: doc/BRIEF.md
# Multiply-Accumulate Operand Bus Controller

This block steers the two operand buses of a small fixed-point signal processor. It holds the two 32-bit multiplier inputs (RX and RY), the 48-bit product register and the 48-bit accumulator. Each instruction carries two independent fields for the X and Y buses. The X field can latch the signed RX×RY product, load the product register from data memory, or load RX from memory. The Y field can clear the accumulator, capture the 48-bit ALU result, load the accumulator from memory, or load RY from memory.

Data memory and the ALU are outside the block. In the same cycle, the block reports which bank each bus reads, a one-hot mask of banks read, and a mask of bank address counters that must advance. The memory returns one word per bus on `x_rd_data` and `y_rd_data` within that cycle. All register updates take effect on the clock edge that ends a cycle in which `instr_valid` is high.

Top module: `mac_opbus`

## Requirements
- R1: After reset, RX, RY, the product register and the accumulator read zero.
- R2: When the X op (instr[25:23]) has its low two bits equal to 2, the product register takes the low 48 bits of the signed 32×32 product of the previous RX and RY.
- R3: When the X op is 3 or more, the X bus reads bank instr[21:20]. That bank's bit is set in `bank_rd_mask`. Its bit in `bank_inc_mask` is set only when instr[22] is 1.
- R4: On an X memory read, the product register takes the word sign-extended to 48 bits when the low two op bits are 3. RX takes the word when op bit 2 is set. Both loads can happen in one instruction.
- R5: When the Y op (instr[19:17]) has low bits 1, the accumulator clears. When they are 2, it takes `alu_result`.
- R6: When the Y op is 3 or more, the Y bus reads bank instr[15:14]. That bank's read bit is set, and its increment bit is set only when instr[16] is 1.
- R7: On a Y memory read, the accumulator takes the word sign-extended when the low two op bits are 3. RY takes the word when op bit 2 is set.
- R8: The read and increment masks are the OR of both buses. Both buses may fetch from and advance counters in the same cycle, and this includes the same bank.
- R9: With `instr_valid` low, both masks are zero and no register changes.
- R10: An X op of 0 or 1 together with a Y op of 0 leaves all four registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| x_rd_data | input | 32 | Word read from the X-selected bank |
| y_rd_data | input | 32 | Word read from the Y-selected bank |
| alu_result | input | 48 | ALU result for the accumulator |
| x_bank | output | 2 | Bank addressed by the X bus |
| y_bank | output | 2 | Bank addressed by the Y bus |
| bank_rd_mask | output | 4 | One-hot-per-bank read mask |
| bank_inc_mask | output | 4 | Counter increment requests |
| rx | output | 32 | RX register |
| ry | output | 32 | RY register |
| p | output | 48 | Product register |
| ac | output | 48 | Accumulator |

## Verification
Bank selects and both masks are combinational, so they are due in the same cycle as the instruction. The driver checks them one time unit after it applies the inputs, which is before the clock edge. The four registers are due one edge later. For each instruction, the driver queues the predicted register values. A monitor removes that entry and compares it a quarter period after the next rising edge, so each prediction meets exactly the edge it belongs to.

// File: rtl/mac_bus_pkg.sv
package mac_bus_pkg;
    localparam int WORD_W  = 32;
    localparam int ACC_W   = 48;
    localparam int N_BANKS = 4;
    localparam int BANK_W  = $clog2(N_BANKS);
    localparam int OP_W    = 3;

    typedef struct packed {
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] ry;
        logic [ACC_W-1:0]  p;
        logic [ACC_W-1:0]  ac;
    } mac_regs_t;

    function automatic logic [ACC_W-1:0] widen_signed(input logic [WORD_W-1:0] w);
        return {{(ACC_W-WORD_W){w[WORD_W-1]}}, w};
    endfunction
endpackage

// File: rtl/mac_src_decode.sv
module mac_src_decode #(
    parameter int N_BANKS = 4,
    parameter int BANK_W  = 2,
    parameter int OP_W    = 3
) (
    input  logic               valid,
    input  logic [OP_W-1:0]    op,
    input  logic [BANK_W:0]    src,
    output logic               rd_en,
    output logic [BANK_W-1:0]  bank,
    output logic [N_BANKS-1:0] rd_onehot,
    output logic [N_BANKS-1:0] inc_onehot
);
    assign rd_en = valid && (op >= OP_W'(3));
    assign bank  = src[BANK_W-1:0];

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        assign rd_onehot[b]  = rd_en && (bank == BANK_W'(b));
        assign inc_onehot[b] = rd_en && (bank == BANK_W'(b)) && src[BANK_W];
    end
endmodule

// File: rtl/mac_opbus.sv
module mac_opbus
    import mac_bus_pkg::*;
#(
    parameter int X_OP_LSB  = 23,
    parameter int X_SRC_LSB = 20,
    parameter int Y_OP_LSB  = 17,
    parameter int Y_SRC_LSB = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [31:0]         instr,
    input  logic [WORD_W-1:0]   x_rd_data,
    input  logic [WORD_W-1:0]   y_rd_data,
    input  logic [ACC_W-1:0]    alu_result,
    output logic [BANK_W-1:0]   x_bank,
    output logic [BANK_W-1:0]   y_bank,
    output logic [N_BANKS-1:0]  bank_rd_mask,
    output logic [N_BANKS-1:0]  bank_inc_mask,
    output logic [WORD_W-1:0]   rx,
    output logic [WORD_W-1:0]   ry,
    output logic [ACC_W-1:0]    p,
    output logic [ACC_W-1:0]    ac
);
    localparam int SRC_W  = BANK_W + 1;
    localparam int PROD_W = 2 * WORD_W;

    logic [OP_W-1:0]    x_op, y_op;
    logic [SRC_W-1:0]   x_src, y_src;
    logic               x_rd_en, y_rd_en;
    logic [N_BANKS-1:0] x_rd_oh, y_rd_oh, x_inc_oh, y_inc_oh;
    logic [PROD_W-1:0]  prod_full;
    mac_regs_t          st_d, st_q;

    assign x_op  = instr[X_OP_LSB  +: OP_W];
    assign x_src = instr[X_SRC_LSB +: SRC_W];
    assign y_op  = instr[Y_OP_LSB  +: OP_W];
    assign y_src = instr[Y_SRC_LSB +: SRC_W];

    mac_src_decode #(.N_BANKS(N_BANKS), .BANK_W(BANK_W), .OP_W(OP_W)) u_xdec (
        .valid(instr_valid), .op(x_op), .src(x_src),
        .rd_en(x_rd_en), .bank(x_bank), .rd_onehot(x_rd_oh), .inc_onehot(x_inc_oh)
    );
    mac_src_decode #(.N_BANKS(N_BANKS), .BANK_W(BANK_W), .OP_W(OP_W)) u_ydec (
        .valid(instr_valid), .op(y_op), .src(y_src),
        .rd_en(y_rd_en), .bank(y_bank), .rd_onehot(y_rd_oh), .inc_onehot(y_inc_oh)
    );

    assign bank_rd_mask  = x_rd_oh  | y_rd_oh;
    assign bank_inc_mask = x_inc_oh | y_inc_oh;

    assign prod_full = PROD_W'($signed(st_q.rx) * $signed(st_q.ry));

    logic unused_bits;
    assign unused_bits = ^{instr[31:26], instr[13:0], prod_full[PROD_W-1:ACC_W]};

    always_comb begin
        st_d = st_q;
        if (instr_valid) begin
            if (x_op[1:0] == 2'd2)
                st_d.p = prod_full[ACC_W-1:0];
            if (x_rd_en) begin
                if (x_op[1:0] == 2'd3) st_d.p  = widen_signed(x_rd_data);
                if (x_op[2])           st_d.rx = x_rd_data;
            end
            case (y_op[1:0])
                2'd1:    st_d.ac = '0;
                2'd2:    st_d.ac = alu_result;
                default: ;
            endcase
            if (y_rd_en) begin
                if (y_op[1:0] == 2'd3) st_d.ac = widen_signed(y_rd_data);
                if (y_op[2])           st_d.ry = y_rd_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx = st_q.rx;
    assign ry = st_q.ry;
    assign p  = st_q.p;
    assign ac = st_q.ac;

    a_r9_idle_masks: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (bank_rd_mask == '0) && (bank_inc_mask == '0));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(rx) && $stable(ry) && $stable(p) && $stable(ac));
    a_r3_x_read_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && x_op >= 3'd3) |-> bank_rd_mask[instr[X_SRC_LSB +: BANK_W]]);
    a_r6_y_read_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && y_op >= 3'd3) |-> bank_rd_mask[instr[Y_SRC_LSB +: BANK_W]]);
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && y_op[1:0] == 2'd1) |=> (ac == '0));
    a_r4_p_load: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && x_op[1:0] == 2'd3) |=>
        (p[WORD_W-1:0] == $past(x_rd_data)) && (p[ACC_W-1:WORD_W] == {(ACC_W-WORD_W){p[WORD_W-1]}}));
    a_r7_ry_load: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && y_op[2]) |=> (ry == $past(y_rd_data)));
    a_r8_inc_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_inc_mask & ~bank_rd_mask) == '0));
endmodule

// File: tb/tb_mac_opbus.sv
module tb_mac_opbus;
    localparam int PERIOD = 10;

    typedef struct {
        logic [31:0] rx, ry;
        logic [47:0] p, ac;
        string       tag;
    } exp_t;

    logic        clk = 0, rst_n = 0, instr_valid = 0;
    logic [31:0] instr = 0, x_rd_data = 0, y_rd_data = 0;
    logic [47:0] alu_result = 0;
    logic [1:0]  x_bank, y_bank;
    logic [3:0]  bank_rd_mask, bank_inc_mask;
    logic [31:0] rx, ry;
    logic [47:0] p, ac;

    int n_chk = 0, n_fail = 0;
    exp_t sb_q[$];
    logic [31:0] m_rx = 0, m_ry = 0;
    logic [47:0] m_p = 0, m_ac = 0;

    always #(PERIOD/2) clk = ~clk;

    mac_opbus dut (.*);

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [47:0] sx(input logic [31:0] w);
        return {{16{w[31]}}, w};
    endfunction

    task automatic step(input logic v, input logic [2:0] xop, input logic [2:0] xs,
                        input logic [2:0] yop, input logic [2:0] ys,
                        input logic [31:0] xd, input logic [31:0] yd,
                        input logic [47:0] alu, input string tag);
        logic [3:0] e_rd, e_inc;
        logic signed [63:0] prod;
        exp_t e;
        @(negedge clk);
        instr_valid = v;
        instr = {6'h2A, xop, xs, yop, ys, 14'h1555};
        x_rd_data = xd; y_rd_data = yd; alu_result = alu;
        #1;
        e_rd = 0; e_inc = 0;
        if (v && xop >= 3) begin e_rd[xs[1:0]] = 1; if (xs[2]) e_inc[xs[1:0]] = 1; end
        if (v && yop >= 3) begin e_rd[ys[1:0]] = 1; if (ys[2]) e_inc[ys[1:0]] = 1; end
        check({tag, " R3/R6 rd_mask"}, "rd_mask", 64'(bank_rd_mask), 64'(e_rd));
        check({tag, " R8 inc_mask"}, "inc_mask", 64'(bank_inc_mask), 64'(e_inc));
        if (v && xop >= 3) check({tag, " R3"}, "x_bank", 64'(x_bank), 64'(xs[1:0]));
        if (v && yop >= 3) check({tag, " R6"}, "y_bank", 64'(y_bank), 64'(ys[1:0]));
        if (v) begin
            prod = $signed(m_rx) * $signed(m_ry);
            if (xop[1:0] == 2) m_p = prod[47:0];
            if (xop == 3 || xop == 7) m_p = sx(xd);
            if (xop[2]) m_rx = xd;
            if (yop[1:0] == 1) m_ac = 0;
            if (yop[1:0] == 2) m_ac = alu;
            if (yop == 3 || yop == 7) m_ac = sx(yd);
            if (yop[2]) m_ry = yd;
        end
        e.rx = m_rx; e.ry = m_ry; e.p = m_p; e.ac = m_ac; e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #(PERIOD/4);
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "rx", 64'(rx), 64'(e.rx));
            check(e.tag, "ry", 64'(ry), 64'(e.ry));
            check(e.tag, "p",  64'(p),  64'(e.p));
            check(e.tag, "ac", 64'(ac), 64'(e.ac));
        end
    end

    initial begin
        #(PERIOD*200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        check("R1 reset", "rx", 64'(rx), 0);
        check("R1 reset", "ry", 64'(ry), 0);
        check("R1 reset", "p",  64'(p),  0);
        check("R1 reset", "ac", 64'(ac), 0);
        rst_n = 1;
        // R4 R7 load RX and RY from different banks, Y increments
        step(1, 3'd4, 3'd1, 3'd4, 3'd6, 32'd7, 32'hFFFF_FFFD, 48'h0, "R4 R7 rx/ry load");
        step(1, 3'd2, 3'd0, 3'd0, 3'd0, 32'h0, 32'h0, 48'h0, "R2 product");
        step(1, 3'd0, 3'd0, 3'd2, 3'd0, 32'h0, 32'h0, 48'h8000_0000_1234, "R5 alu");
        step(1, 3'd0, 3'd0, 3'd1, 3'd0, 32'h0, 32'h0, 48'h0, "R5 clear");
        step(1, 3'd3, 3'd4, 3'd3, 3'd0, 32'h8000_0001, 32'h7FFF_FFFF, 48'h0, "R8 R4 R7 same bank");
        step(1, 3'd7, 3'd7, 3'd7, 3'd5, 32'hFFFF_FFF0, 32'h1234_5678, 48'h0, "R4 R7 dual load");
        step(1, 3'd6, 3'd2, 3'd5, 3'd3, 32'h0000_0100, 32'h0000_0003, 48'h0, "R2 R5 R6 mixed");
        step(0, 3'd7, 3'd6, 3'd7, 3'd6, 32'hDEAD_BEEF, 32'hCAFE_F00D, 48'hFFFF, "R9 invalid");
        step(1, 3'd1, 3'd5, 3'd0, 3'd7, 32'h1111_1111, 32'h2222_2222, 48'h0, "R10 nop");
        step(1, 3'd0, 3'd5, 3'd0, 3'd7, 32'h3333_3333, 32'h4444_4444, 48'h0, "R10 nop zero");
        step(1, 3'd4, 3'd3, 3'd4, 3'd7, 32'h8000_0000, 32'h8000_0000, 48'h0, "R4 R7 min load");
        step(1, 3'd2, 3'd0, 3'd6, 3'd6, 32'h0, 32'h0, 48'h0000_FFFF_0000, "R2 truncation");
        step(1, 3'd5, 3'd2, 3'd5, 3'd6, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 48'h0, "R4 R7 load2");
        step(1, 3'd2, 3'd0, 3'd3, 3'd2, 32'h0, 32'hFFFF_FFFF, 48'h0, "R2 R7 neg product");
        @(negedge clk);
        instr_valid = 0;
        repeat (3) @(posedge clk);
        #(PERIOD/2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule